// File: doc/BRIEF.md
# Zero-Guarded Semaphore Register Bank

This block holds a set of small lock registers that several cores, hosts or software tasks use to share resources safely. Every requester has its own nonzero 8-bit code. To take a lock, a requester writes its code into one semaphore register and then reads that register back. If the value read matches its own code, the requester owns the lock. To give the lock up, it writes zero.

Exclusion comes from a write guard on each register. A register that holds zero accepts any value. A register that holds a nonzero value accepts only zero. Nonzero writes to an occupied register are dropped without any indication, so a late contender's code never overwrites the owner's code.

The bank is reached through one or more plain register-bus ports. Each port has an address, a write enable with write data, and a read enable with registered read data. There is no handshake: every access completes in the cycle it is presented.

Top module: `sem_bank`

## Requirements
- R1: After reset (rst_n low, asynchronous) every semaphore register reads 0x00 and every port's read data is 0x00.
- R2: A write to a register that holds 0x00 stores the written value, whatever it is.
- R3: A nonzero write to a register that holds a nonzero value is ignored, and the register keeps its value.
- R4: A write of 0x00 to any in-range register sets it to 0x00. This releases the lock.
- R5: A read registers the value the addressed semaphore held before the clock edge and presents it on that port's rd_data in the next cycle. A write to the same register in the same cycle does not affect the value read. In a cycle after no read, rd_data is 0x00.
- R6: Reads never change any register. In a cycle with no write enabled on any port, all registers keep their values.
- R7: When several ports write the same register in one cycle, only the lowest-numbered of those ports takes part. Port 0 beats port 1. The guard is evaluated on that port's data against the register's value before the cycle. The data from higher-numbered ports is discarded, even if the winning write is rejected.
- R8: Addresses 0 to 7 select the registers. Any address of 8 or above (the address is 4 bits wide by default) is outside the bank. A write there changes no register, and a read there returns 0x00.
- R9: The registers are independent. A write to one register never changes another.
- R10: Suppose two requesters with distinct codes each write their code to the same free register in successive cycles and then read it back. The first requester reads its own code, and the second requester reads the first requester's code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | NPORTS | Per-port write enable |
| addr | input | NPORTS x ADDR_W | Per-port register address |
| wr_data | input | NPORTS x SEM_W | Per-port write data |
| rd_en | input | NPORTS | Per-port read enable |
| rd_data | output | NPORTS x SEM_W | Per-port registered read data |

## Verification
The assertions check on every cycle that:
- an occupied register changes only to zero;
- a cycle with no writes leaves the bank untouched;
- a free register takes the data of port 0;
- a zero write from port 0 always releases the register;
- out-of-range reads and idle ports return zero.

Some behaviours can only be shown by the bench scenarios, which compare the read data against a behavioural model on every clock. These are:
- the full acquire-and-check handshake between two requesters;
- the priority rule when the winning port's write is rejected and the losing port's write is dropped;
- the value returned by a read that shares its cycle with a write to the same register.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int DEF_NPORTS = 2;
  localparam int DEF_NSEM   = 8;
  localparam int DEF_SEM_W  = 8;
  localparam int DEF_ADDR_W = 4;
endpackage

// File: rtl/sem_addr_decode.sv
module sem_addr_decode #(
  parameter int NSEM   = sem_pkg::DEF_NSEM,
  parameter int ADDR_W = sem_pkg::DEF_ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_range,
  output logic [NSEM-1:0]   sel
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NSEM);

  assign in_range = ({1'b0, addr} < LIMIT);

  for (genvar i = 0; i < NSEM; i++) begin : g_sel
    assign sel[i] = in_range && (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell #(
  parameter int NPORTS = sem_pkg::DEF_NPORTS,
  parameter int SEM_W  = sem_pkg::DEF_SEM_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORTS-1:0]            hit,
  input  logic [NPORTS-1:0][SEM_W-1:0] wdata,
  output logic [SEM_W-1:0]             value
);
  logic             win;
  logic [SEM_W-1:0] win_data;
  logic             accept;

  // Lowest-numbered requesting port wins; scan from the top down.
  always_comb begin
    win      = 1'b0;
    win_data = '0;
    for (int p = NPORTS - 1; p >= 0; p--) begin
      if (hit[p]) begin
        win      = 1'b1;
        win_data = wdata[p];
      end
    end
  end

  // Guard against the value held before this edge.
  assign accept = win && ((value == '0) || (win_data == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else if (accept) value <= win_data;
  end
endmodule

// File: rtl/sem_rd_port.sv
module sem_rd_port #(
  parameter int NSEM   = sem_pkg::DEF_NSEM,
  parameter int SEM_W  = sem_pkg::DEF_SEM_W,
  parameter int ADDR_W = sem_pkg::DEF_ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_en,
  input  logic                       in_range,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NSEM-1:0][SEM_W-1:0] bank,
  output logic [SEM_W-1:0]           rd_data
);
  logic [SEM_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NSEM; i++) begin
      if (in_range && (addr == ADDR_W'(i))) picked = bank[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= picked;
    else rd_data <= '0;
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NPORTS = sem_pkg::DEF_NPORTS,
  parameter int NSEM   = sem_pkg::DEF_NSEM,
  parameter int SEM_W  = sem_pkg::DEF_SEM_W,
  parameter int ADDR_W = sem_pkg::DEF_ADDR_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORTS-1:0]             wr_en,
  input  logic [NPORTS-1:0][ADDR_W-1:0] addr,
  input  logic [NPORTS-1:0][SEM_W-1:0]  wr_data,
  input  logic [NPORTS-1:0]             rd_en,
  output logic [NPORTS-1:0][SEM_W-1:0]  rd_data
);
  logic [NPORTS-1:0]            in_range;
  logic [NPORTS-1:0][NSEM-1:0]  sel;
  logic [NSEM-1:0][NPORTS-1:0]  hit;
  logic [NSEM-1:0][SEM_W-1:0]   sem_q;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    sem_addr_decode #(.NSEM(NSEM), .ADDR_W(ADDR_W)) dec_i (
      .addr     (addr[p]),
      .in_range (in_range[p]),
      .sel      (sel[p])
    );

    sem_rd_port #(.NSEM(NSEM), .SEM_W(SEM_W), .ADDR_W(ADDR_W)) rd_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en[p]),
      .in_range (in_range[p]),
      .addr     (addr[p]),
      .bank     (sem_q),
      .rd_data  (rd_data[p])
    );
  end

  for (genvar r = 0; r < NSEM; r++) begin : g_sem
    for (genvar p = 0; p < NPORTS; p++) begin : g_hit
      assign hit[r][p] = wr_en[p] && sel[p][r];
    end

    sem_cell #(.NPORTS(NPORTS), .SEM_W(SEM_W)) cell_i (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit[r]),
      .wdata (wr_data),
      .value (sem_q[r])
    );
  end
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int NPORTS = sem_pkg::DEF_NPORTS,
  parameter int NSEM   = sem_pkg::DEF_NSEM,
  parameter int SEM_W  = sem_pkg::DEF_SEM_W,
  parameter int ADDR_W = sem_pkg::DEF_ADDR_W
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NPORTS-1:0]             wr_en,
  input logic [NPORTS-1:0][ADDR_W-1:0] addr,
  input logic [NPORTS-1:0][SEM_W-1:0]  wr_data,
  input logic [NPORTS-1:0]             rd_en,
  input logic [NPORTS-1:0][SEM_W-1:0]  rd_data,
  input logic [NSEM-1:0][SEM_W-1:0]    sem_q
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NSEM);

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) |=> $stable(sem_q));

  for (genvar i = 0; i < NSEM; i++) begin : g_reg
    p_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sem_q[i]) != '0 && sem_q[i] != $past(sem_q[i])) |-> (sem_q[i] == '0));

    // Port 0 always wins, so its write to a free register lands (R2, R7).
    p_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[0] && addr[0] == ADDR_W'(i) && sem_q[i] == '0) |=> (sem_q[i] == $past(wr_data[0])));

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[0] && addr[0] == ADDR_W'(i) && wr_data[0] == '0) |=> (sem_q[i] == '0));
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_prt
    p_outrange_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en[p] && ({1'b0, addr[p]} >= LIMIT)) |=> (rd_data[p] == '0));

    p_idle_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en[p]) |=> (rd_data[p] == '0));
  end
endmodule

bind sem_bank sem_bank_chk #(
  .NPORTS(NPORTS), .NSEM(NSEM), .SEM_W(SEM_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .sem_q(sem_q)
);

// File: tb/sem_bank_tb_top.sv
`timescale 1ns/1ps
module sem_bank_tb_top;
  localparam int NP = 2;
  localparam int NS = 8;
  localparam int W  = 8;
  localparam int AW = 4;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NP-1:0]         wr_en = '0;
  logic [NP-1:0][AW-1:0] addr = '0;
  logic [NP-1:0][W-1:0]  wr_data = '0;
  logic [NP-1:0]         rd_en = '0;
  logic [NP-1:0][W-1:0]  rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cmp_en = 1'b0;
  string cur_req = "R1";

  int model [NS];
  int exp_rd [NP];

  sem_bank #(.NPORTS(NP), .NSEM(NS), .SEM_W(W), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  // Behavioural reference: reads see pre-edge values, then writes apply.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) model[i] = 0;
      for (int p = 0; p < NP; p++) exp_rd[p] = 0;
    end else begin
      for (int p = 0; p < NP; p++)
        exp_rd[p] = (rd_en[p] && int'(addr[p]) < NS) ? model[addr[p]] : 0;
      for (int r = 0; r < NS; r++) begin
        int wp;
        wp = -1;
        for (int p = NP - 1; p >= 0; p--)
          if (wr_en[p] && int'(addr[p]) == r) wp = p;
        if (wp >= 0 && (model[r] == 0 || int'(wr_data[wp]) == 0))
          model[r] = int'(wr_data[wp]);
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      for (int p = 0; p < NP; p++) begin
        checks++;
        if (int'(rd_data[p]) != exp_rd[p]) begin
          errors++;
          $display("FAIL %s model port%0d actual %0h expected %0h", cur_req, p, rd_data[p], exp_rd[p]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <= 20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input bit w0, input int a0, input int d0, input bit r0, input int ra0,
                     input bit w1, input int a1, input int d1, input bit r1, input int ra1);
    @(negedge clk); #1;
    wr_en[0] = w0; wr_en[1] = w1; rd_en[0] = r0; rd_en[1] = r1;
    wr_data[0] = W'(d0); wr_data[1] = W'(d1);
    addr[0] = AW'(w0 ? a0 : ra0); addr[1] = AW'(w1 ? a1 : ra1);
  endtask

  task automatic idle();
    @(negedge clk); #1;
    wr_en = '0; rd_en = '0; wr_data = '0; addr = '0;
  endtask

  // Checks rd_data of the previous cycle's read against a fixed value.
  task automatic expect_rd(input int p, input int val, input string req);
    @(negedge clk);
    checks++;
    if (int'(rd_data[p]) != val) begin
      errors++;
      $display("FAIL %s port%0d actual %0h expected %0h", req, p, rd_data[p], val);
    end
    #1; wr_en = '0; rd_en = '0; wr_data = '0; addr = '0;
  endtask

  task automatic rd(input int p, input int a, input int val, input string req);
    if (p == 0) cyc(0, 0, 0, 1, a, 0, 0, 0, 0, 0);
    else        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, a);
    expect_rd(p, val, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    // R1: everything free after reset
    cur_req = "R1";
    for (int i = 0; i < NS; i++) rd(i % 2, i, 0, "R1");
    // R2: free register takes any value
    cur_req = "R2";
    cyc(1, 2, 'h5A, 0, 0, 0, 0, 0, 0, 0); idle();
    rd(0, 2, 'h5A, "R2");
    // R3: nonzero write to held register ignored
    cur_req = "R3";
    cyc(0, 0, 0, 0, 0, 1, 2, 'h33, 0, 0); idle();
    rd(1, 2, 'h5A, "R3");
    // R5: same-cycle write and read returns pre-edge value
    cur_req = "R5";
    cyc(1, 2, 0, 0, 0, 0, 0, 0, 1, 2);
    expect_rd(1, 'h5A, "R5");
    // R4: released
    cur_req = "R4";
    rd(0, 2, 0, "R4");
    // R10: two requesters contend
    cur_req = "R10";
    cyc(1, 5, 'h11, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 5, 'h22, 0, 0);
    cyc(0, 0, 0, 1, 5, 0, 0, 0, 1, 5);
    expect_rd(0, 'h11, "R10");
    rd(1, 5, 'h11, "R10");
    // R7: same-cycle contention
    cur_req = "R7";
    cyc(1, 6, 'h41, 0, 0, 1, 6, 'h42, 0, 0); idle();
    rd(1, 6, 'h41, "R7");
    cyc(1, 6, 'h77, 0, 0, 1, 6, 0, 0, 0); idle();
    rd(0, 6, 'h41, "R7");
    cyc(1, 6, 0, 0, 0, 1, 6, 'h55, 0, 0); idle();
    rd(1, 6, 0, "R7");
    // R8: out-of-range accesses
    cur_req = "R8";
    cyc(1, 9, 'h99, 0, 0, 1, 15, 'h66, 0, 0); idle();
    for (int i = 0; i < NS; i++) rd(0, i, (i == 5) ? 'h11 : 0, "R8");
    rd(1, 12, 0, "R8");
    // R6: repeated reads have no effect
    cur_req = "R6";
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, 5, 0, 0, 0, 1, 5);
    idle();
    rd(0, 5, 'h11, "R6");
    // R9: independent registers
    cur_req = "R9";
    cyc(1, 0, 'hA0, 0, 0, 1, 7, 'hB7, 0, 0); idle();
    rd(0, 0, 'hA0, "R9");
    rd(1, 7, 'hB7, "R9");
    rd(0, 5, 'h11, "R9");
    // R9: mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      int v0, v1;
      v0 = $urandom % 3; v1 = $urandom % 3;
      cyc($urandom % 2 == 0, $urandom % 10, (v0 == 0) ? 0 : ($urandom % 256), $urandom % 2 == 0, $urandom % 10,
          $urandom % 2 == 0, $urandom % 10, (v1 == 0) ? 0 : ($urandom % 256), $urandom % 2 == 0, $urandom % 10);
    end
    idle();
    idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule